// File: doc/BRIEF.md
# Windowed Address Translator

This block turns the addresses issued by a processor core into physical targets. A 16-bit data address and an 18-bit instruction address are each decoded, in the same cycle, into a target (internal data RAM, instruction memory or unified memory), a physical byte offset and, for unified memory, a segment number. Three 16-bit map registers steer the decode. One governs a 16 KB data window. The other two govern the instruction space, one for each half of it.

Most of the data space maps straight onto internal data RAM. Only the 16 KB window at 0x8000–0xBFFF is redirected by the data map. The top quarter of the data space is I/O. An access there still reaches data RAM, but it raises a bus error unless it falls in the 16-byte register hole at 0xFF00–0xFF0F. The translation paths are purely combinational, so there is no back-pressure: every address is accepted and its result is valid in the same cycle. Map registers are loaded through a plain write port.

Top module: `win_addr_xlat`

## Requirements
- R1: A data address below 0x8000 gives target 0 (data RAM), offset equal to the address, segment 0 and no bus error. Target codes are 0 for data RAM, 1 for instruction memory and 2 for unified memory.
- R2: A data address of 0xC000 or above gives target 0 with offset equal to the address. When the access is valid, the bus error is raised exactly when address bits [15:4] differ from 0xFF0.
- R3: The bus error is never raised while `d_valid` is low.
- R4: For a data address in 0x8000–0xBFFF with data map bit 12 set, the target is 1. The offset is data map bits [3:0] times 0x4000 plus (address − 0x8000), and the segment is 0.
- R5: For a data address in 0x8000–0xBFFF with data map bit 12 clear, the target is 2. The segment is data map bits [9:3], and the offset is data map bits [2:0] times 0x4000 plus (address − 0x8000).
- R6: Instruction address bit 17 selects the second instruction map when it is 1 and the first instruction map when it is 0.
- R7: If the selected instruction map has bit 12 set, the instruction target is 1 with offset equal to the full address and segment 0. Otherwise the target is 2, the segment is map bits [7:0] and the offset is address bits [16:0].
- R8: After reset the data map is 0x0000, the first instruction map is 0x0000 and the second is 0x007F.
- R9: A write with `cfg_we` high loads `cfg_wdata` at the clock edge, and the new value governs translations from the next cycle on. `cfg_sel` 0 selects the data map, 1 the first instruction map and 2 the second. `cfg_sel` 3 changes no map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Map register write strobe |
| cfg_sel | input | 2 | Map register select |
| cfg_wdata | input | 16 | Map register write value |
| d_valid | input | 1 | Data access valid, qualifies the bus error |
| d_addr | input | 16 | Logical data address |
| d_tgt | output | 2 | Data target code |
| d_off | output | 18 | Data physical offset |
| d_seg | output | 8 | Data unified segment number |
| d_berr | output | 1 | Data bus error |
| i_addr | input | 18 | Instruction address |
| i_tgt | output | 2 | Instruction target code |
| i_off | output | 18 | Instruction physical offset |
| i_seg | output | 8 | Instruction unified segment number |

## Verification
The bench builds the block with its default parameters: 16-bit data addresses, 18-bit instruction addresses and an 8-bit segment field. At these widths every region edge can be driven directly: 0x7FFF/0x8000, 0xBFFF/0xC000, and both sides of the I/O hole at 0xFEFF, 0xFF00, 0xFF0F and 0xFF10. The 2-bit select also lets the unused select code be exercised. Directed cases cover these edges, the reset maps and a write landing one cycle later. Random addresses and map writes then run against a behavioural model that is compared every cycle.

// File: rtl/wax_pkg.sv
package wax_pkg;
  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_IMEM = 2'd1,
    TGT_UMEM = 2'd2
  } tgt_e;

  localparam int MAP_W       = 16;
  localparam int MAP_IMEM    = 12;  // map bit choosing instruction memory
  localparam int DW_IBANK_HI = 3;   // data window bank into instruction memory
  localparam int DW_UBANK_HI = 2;   // data window bank inside a unified segment
  localparam int DW_SEG_LO   = 3;
  localparam int DW_SEG_HI   = 9;
  localparam int IW_SEG_HI   = 7;

  localparam logic [1:0] SEL_DMAP  = 2'd0;
  localparam logic [1:0] SEL_IMAP0 = 2'd1;
  localparam logic [1:0] SEL_IMAP1 = 2'd2;
endpackage

// File: rtl/wax_map_regs.sv
module wax_map_regs
  import wax_pkg::*;
#(
  parameter logic [MAP_W-1:0] DMAP_RST  = 16'h0000,
  parameter logic [MAP_W-1:0] IMAP0_RST = 16'h0000,
  parameter logic [MAP_W-1:0] IMAP1_RST = 16'h007F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [MAP_W-1:0] wdata,
  output logic [MAP_W-1:0] dmap,
  output logic [MAP_W-1:0] imap0,
  output logic [MAP_W-1:0] imap1
);
  localparam int NREG = 3;
  localparam logic [NREG-1:0][MAP_W-1:0] RSTV = {IMAP1_RST, IMAP0_RST, DMAP_RST};

  logic [NREG-1:0][MAP_W-1:0] regs;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= RSTV[g];
      else if (we && sel == 2'(g))
        regs[g] <= wdata;
    end
  end

  assign dmap  = regs[SEL_DMAP];
  assign imap0 = regs[SEL_IMAP0];
  assign imap1 = regs[SEL_IMAP1];
endmodule

// File: rtl/wax_dmap.sv
module wax_dmap
  import wax_pkg::*;
#(
  parameter int DAW   = 16,
  parameter int OFF_W = 18,
  parameter int SEG_W = 8,
  parameter logic [DAW-5:0] IO_TAG = 12'hFF0
) (
  input  logic             valid,
  input  logic [DAW-1:0]   addr,
  input  logic [MAP_W-1:0] map,
  output tgt_e             tgt,
  output logic [OFF_W-1:0] off,
  output logic [SEG_W-1:0] seg,
  output logic             berr
);
  localparam int WB = DAW - 2;  // window offset bits

  logic unused_map;
  assign unused_map = ^{map[MAP_W-1:MAP_IMEM+1], map[MAP_IMEM-1:DW_SEG_HI+1]};

  always_comb begin
    tgt  = TGT_DRAM;
    off  = OFF_W'(addr);
    seg  = '0;
    berr = 1'b0;
    case (addr[DAW-1 -: 2])
      2'b10: begin
        if (map[MAP_IMEM]) begin
          tgt = TGT_IMEM;
          off = OFF_W'({map[DW_IBANK_HI:0], addr[WB-1:0]});
        end else begin
          tgt = TGT_UMEM;
          off = OFF_W'({map[DW_UBANK_HI:0], addr[WB-1:0]});
          seg = SEG_W'(map[DW_SEG_HI:DW_SEG_LO]);
        end
      end
      2'b11: berr = valid && (addr[DAW-1:4] != IO_TAG);
      default: ;
    endcase
  end
endmodule

// File: rtl/wax_imap.sv
module wax_imap
  import wax_pkg::*;
#(
  parameter int IAW    = 18,
  parameter int UOFF_W = 17,
  parameter int OFF_W  = 18,
  parameter int SEG_W  = 8
) (
  input  logic [IAW-1:0]   addr,
  input  logic [MAP_W-1:0] map0,
  input  logic [MAP_W-1:0] map1,
  output tgt_e             tgt,
  output logic [OFF_W-1:0] off,
  output logic [SEG_W-1:0] seg
);
  logic [MAP_W-1:0] msel;
  assign msel = addr[IAW-1] ? map1 : map0;

  logic unused_msel;
  assign unused_msel = ^{msel[MAP_W-1:MAP_IMEM+1], msel[MAP_IMEM-1:IW_SEG_HI+1]};

  always_comb begin
    if (msel[MAP_IMEM]) begin
      tgt = TGT_IMEM;
      off = OFF_W'(addr);
      seg = '0;
    end else begin
      tgt = TGT_UMEM;
      off = OFF_W'(addr[UOFF_W-1:0]);
      seg = SEG_W'(msel[IW_SEG_HI:0]);
    end
  end
endmodule

// File: rtl/win_addr_xlat.sv
module win_addr_xlat
  import wax_pkg::*;
#(
  parameter int DAW    = 16,
  parameter int IAW    = 18,
  parameter int UOFF_W = 17,
  parameter int SEG_W  = 8,
  parameter logic [MAP_W-1:0] DMAP_RST  = 16'h0000,
  parameter logic [MAP_W-1:0] IMAP0_RST = 16'h0000,
  parameter logic [MAP_W-1:0] IMAP1_RST = 16'h007F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [MAP_W-1:0]  cfg_wdata,
  input  logic              d_valid,
  input  logic [DAW-1:0]    d_addr,
  output logic [1:0]        d_tgt,
  output logic [IAW-1:0]    d_off,
  output logic [SEG_W-1:0]  d_seg,
  output logic              d_berr,
  input  logic [IAW-1:0]    i_addr,
  output logic [1:0]        i_tgt,
  output logic [IAW-1:0]    i_off,
  output logic [SEG_W-1:0]  i_seg
);
  localparam int OFF_W = IAW;

  logic [MAP_W-1:0] dmap, imap0, imap1;
  tgt_e dt, it;

  wax_map_regs #(.DMAP_RST(DMAP_RST), .IMAP0_RST(IMAP0_RST), .IMAP1_RST(IMAP1_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .dmap(dmap), .imap0(imap0), .imap1(imap1)
  );

  wax_dmap #(.DAW(DAW), .OFF_W(OFF_W), .SEG_W(SEG_W)) u_dmap (
    .valid(d_valid), .addr(d_addr), .map(dmap),
    .tgt(dt), .off(d_off), .seg(d_seg), .berr(d_berr)
  );

  wax_imap #(.IAW(IAW), .UOFF_W(UOFF_W), .OFF_W(OFF_W), .SEG_W(SEG_W)) u_imap (
    .addr(i_addr), .map0(imap0), .map1(imap1),
    .tgt(it), .off(i_off), .seg(i_seg)
  );

  assign d_tgt = dt;
  assign i_tgt = it;
endmodule

// File: rtl/wax_chk.sv
module wax_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        d_valid,
  input logic [15:0] d_addr,
  input logic [1:0]  d_tgt,
  input logic [17:0] d_off,
  input logic        d_berr,
  input logic [17:0] i_addr,
  input logic [1:0]  i_tgt,
  input logic [17:0] i_off,
  input logic [7:0]  i_seg
);
  AST_LOW_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    !d_addr[15] |-> (d_tgt == 2'd0 && d_off == {2'b00, d_addr} && !d_berr)); // R1

  AST_HOLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (d_addr[15:4] == 12'hFF0) |-> !d_berr); // R2

  AST_BERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !d_valid |-> !d_berr); // R3

  AST_UMEM_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (d_tgt == 2'd2) |-> !d_off[17]); // R5

  AST_I_UMEM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (i_tgt == 2'd2) |-> (i_off == {1'b0, i_addr[16:0]})); // R7

  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we ##1 $stable(i_addr)) |-> $stable({i_tgt, i_off, i_seg})); // R9
endmodule

bind win_addr_xlat wax_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .d_valid(d_valid), .d_addr(d_addr),
  .d_tgt(d_tgt), .d_off(d_off), .d_berr(d_berr),
  .i_addr(i_addr), .i_tgt(i_tgt), .i_off(i_off), .i_seg(i_seg)
);

// File: tb/tb_win_addr_xlat.sv
`timescale 1ns/1ps
module tb_win_addr_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'h0;
  logic        d_valid = 1'b0;
  logic [15:0] d_addr = 16'h0;
  logic [1:0]  d_tgt;
  logic [17:0] d_off;
  logic [7:0]  d_seg;
  logic        d_berr;
  logic [17:0] i_addr = 18'h0;
  logic [1:0]  i_tgt;
  logic [17:0] i_off;
  logic [7:0]  i_seg;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  win_addr_xlat dut (.*);

  // behavioural model of the three maps
  int m_d, m_i0, m_i1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_d = 0; m_i0 = 0; m_i1 = 'h7F;
    end else if (cfg_we) begin
      if (cfg_sel == 0) m_d = cfg_wdata;
      else if (cfg_sel == 1) m_i0 = cfg_wdata;
      else if (cfg_sel == 2) m_i1 = cfg_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int a, t, o, s, b, m;
      string tag;
      a = d_addr;
      s = 0; b = 0;
      if (a < 'h8000) begin t = 0; o = a; tag = "R1"; end
      else if (a < 'hC000) begin
        if ((m_d >> 12) & 1) begin t = 1; o = (m_d & 15) * 'h4000 + (a - 'h8000); tag = "R4"; end
        else begin t = 2; o = (m_d & 7) * 'h4000 + (a - 'h8000); s = (m_d >> 3) & 127; tag = "R5"; end
      end else begin
        t = 0; o = a; tag = "R2";
        b = (d_valid && ((a >> 4) != 'hFF0)) ? 1 : 0;
      end
      chk(d_tgt == t, {tag, " d_tgt"}, d_tgt, t);
      chk(d_off == o, {tag, " d_off"}, d_off, o);
      chk(d_seg == s, {tag, " d_seg"}, d_seg, s);
      chk(d_berr == b, d_valid ? "R2 d_berr" : "R3 d_berr", d_berr, b);
      a = i_addr;
      m = ((a >> 17) & 1) ? m_i1 : m_i0;  // R6
      if ((m >> 12) & 1) begin t = 1; o = a; s = 0; end
      else begin t = 2; o = a % 'h20000; s = m & 255; end
      chk(i_tgt == t, "R7 i_tgt", i_tgt, t);
      chk(i_off == o, "R7 i_off", i_off, o);
      chk(i_seg == s, "R6 i_seg", i_seg, s);
    end
  end

  task automatic step;
    @(posedge clk); #2;
  endtask

  task automatic dcheck(input string tag, input int t, input int o, input int s);
    @(negedge clk); #1;
    chk(d_tgt == t, {tag, " dir d_tgt"}, d_tgt, t);
    chk(d_off == o, {tag, " dir d_off"}, d_off, o);
    chk(d_seg == s, {tag, " dir d_seg"}, d_seg, s);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R8: reset maps
    d_valid = 1; d_addr = 16'h8123; i_addr = 18'h20040;
    dcheck("R8", 2, 'h123, 0);
    chk(i_seg == 'h7F, "R8 i_seg imap1", i_seg, 'h7F);
    chk(i_off == 'h40, "R8 i_off", i_off, 'h40);
    step();
    i_addr = 18'h00040;
    @(negedge clk); #1;
    chk(i_seg == 0 && i_tgt == 2, "R6 first map", i_seg, 0);
    step();
    // R1 edge
    d_addr = 16'h7FFF;
    dcheck("R1", 0, 'h7FFF, 0);
    step();
    // R2 hole edges
    d_addr = 16'hFF00; @(negedge clk); #1; chk(d_berr == 0, "R2 hole low", d_berr, 0);
    step(); d_addr = 16'hFF0F; @(negedge clk); #1; chk(d_berr == 0, "R2 hole high", d_berr, 0);
    step(); d_addr = 16'hFF10; @(negedge clk); #1; chk(d_berr == 1, "R2 above hole", d_berr, 1);
    step(); d_addr = 16'hC000; @(negedge clk); #1; chk(d_berr == 1, "R2 io base", d_berr, 1);
    step(); d_valid = 0; @(negedge clk); #1; chk(d_berr == 0, "R3 invalid", d_berr, 0);
    step();
    // R9 timing: write data map, takes effect next cycle
    d_valid = 1; d_addr = 16'hBFFF;
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 16'h1005;
    dcheck("R9 before edge", 2, 'h3FFF, 0);
    step(); cfg_we = 0;
    dcheck("R4", 1, 5 * 'h4000 + 'h3FFF, 0);
    // R9: select 3 ignored
    cfg_we = 1; cfg_sel = 3; cfg_wdata = 16'h0000;
    step(); cfg_we = 0;
    dcheck("R9 sel3", 1, 5 * 'h4000 + 'h3FFF, 0);
    // R5 unified window
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 16'h03FE;
    step(); cfg_we = 0; d_addr = 16'h8000;
    dcheck("R5", 2, 6 * 'h4000, 'h7F);
    // R7 instruction map to instruction memory
    cfg_we = 1; cfg_sel = 2; cfg_wdata = 16'h1000;
    step(); cfg_we = 0; i_addr = 18'h3FFFF;
    @(negedge clk); #1;
    chk(i_tgt == 1 && i_off == 'h3FFFF, "R7 imem", i_off, 'h3FFFF);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      step();
      d_valid = 1'($urandom);
      d_addr = 16'($urandom);
      if (($urandom % 4) == 0) d_addr = 16'hFF00 | 16'($urandom % 32);
      i_addr = 18'($urandom);
      cfg_we = (($urandom % 5) == 0);
      cfg_sel = 2'($urandom);
      cfg_wdata = 16'($urandom);
    end
    step(); cfg_we = 0;
    step();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule